// File: doc/BRIEF.md
# Bidirectional Row-Scan Token Shifter

This block walks one or more row-select tokens through the rows of a passive-matrix display. A chain of cells, one per row, holds a one-hot (or two-hot) pattern. On every rising clock edge each token moves one row in the chosen direction. The row whose cell holds a token is the active row for that scan slot. A token that moves past the far end drops out of the chain and is also presented on a pin, so that a second chain can be cascaded after this one.

There are two token pins, one at the row-0 end and one at the top-row end. The direction control decides which pin accepts the entry pulse and which one carries the leaving token. When the entry pin is high at a clock edge, one or more seed tokens are loaded on that edge. Where they land depends on three things: the direction, single or dual mode, and whether the panel uses all rows or the reduced 120-row layout. Dual mode places a second token at the middle of the chain, which halves the scan time per frame. Reduced mode adds a token four cells in from the entry end, so that the rows used by a 120-row panel start scanning in step with the others. Reset clears every cell at any time, which cuts the scan short.

Top module: `row_token_shifter`

## Requirements
- R1: While rst_n is low at a rising edge, every row_active bit is 0 after that edge. Both exit outputs read 0 at once, without waiting for an edge, whenever rst_n is low.
- R2: With dir_up=1, a token in row i (i < 127) is in row i+1 after the next rising edge.
- R3: With dir_up=0, a token in row i (i > 0) is in row i-1 after the next rising edge.
- R4: With full_mode=1 and dual_en=0, an entry pulse seeds row 0 when dir_up=1 (entry on lo_pin_in), or row 127 when dir_up=0 (entry on hi_pin_in). The seeded row reads active after the edge that samples the pulse.
- R5: With dual_en=1, the same pulse also seeds the middle of the chain: row 64 when dir_up=1, or row 63 when dir_up=0.
- R6: With full_mode=0, the pulse also seeds the cell four rows in from the entry end: row 4 when dir_up=1, or row 123 when dir_up=0. This adds to any seeds from R4 and R5.
- R7: The direction sets the pin roles. With dir_up=1, lo_pin_oe=0, hi_pin_oe=1, lo_pin_out=0, and hi_pin_in has no effect. With dir_up=0, the roles swap: hi_pin_oe=0, lo_pin_oe=1, hi_pin_out=0, and lo_pin_in has no effect.
- R8: The exit output equals the content of the last cell in the current direction: hi_pin_out = row_active[127] when dir_up=1, and lo_pin_out = row_active[0] when dir_up=0.
- R9: A token in the last cell leaves the chain on the next edge. It does not wrap around, so the chain is empty 128 edges after a single seed.
- R10: Right after one entry pulse into an empty chain, the number of active rows equals the number of seeds: 1, plus 1 for dual mode, plus 1 for reduced mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low clear; also masks the exit outputs at once |
| dir_up | input | 1 | 1: tokens move toward row 127; 0: toward row 0 |
| dual_en | input | 1 | 1: each entry pulse also seeds the middle cell |
| full_mode | input | 1 | 1: all 128 rows; 0: 120-row layout with an extra seed |
| lo_pin_in | input | 1 | Row-0-end token pin, input side (entry when dir_up=1) |
| lo_pin_out | output | 1 | Row-0-end token pin, output side (exit when dir_up=0) |
| lo_pin_oe | output | 1 | Drive enable for the row-0-end pin |
| hi_pin_in | input | 1 | Top-end token pin, input side (entry when dir_up=0) |
| hi_pin_out | output | 1 | Top-end token pin, output side (exit when dir_up=1) |
| hi_pin_oe | output | 1 | Drive enable for the top-end pin |
| row_active | output | 128 | One flag per row, high while that row holds a token |

## Verification
A seed and each step of a token are due one rising edge after the inputs that cause them. The exit pins and their enables follow the cell contents, direction and reset combinationally. For this reason the bench sets its inputs just after a falling edge, waits a short settle time, and compares the pins against the model state built at the previous edge. After the comparison, the model applies the new inputs to give the state due after the coming rising edge. Seed positions and active-row counts are checked in the half cycle right after the pulse edge. The absence of wrap-around is checked once the full chain length of edges has passed.

// File: rtl/row_scan_pkg.sv
// Shared constants for the row-scan token shifter.
// Assumes: chain length is even so a middle seed exists.
package row_scan_pkg;
    localparam int DEF_ROWS      = 128;
    localparam int DEF_EDGE_SKIP = 4;
endpackage

// File: rtl/seed_decoder.sv
// Turns one entry pulse into the set of cells to load, by direction,
// single/dual mode and full/reduced mode.
// Assumes: entry is already taken from the pin that faces the scan start.
module seed_decoder #(
    parameter int ROWS      = row_scan_pkg::DEF_ROWS,
    parameter int EDGE_SKIP = row_scan_pkg::DEF_EDGE_SKIP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dir_up,
    input  logic            dual_en,
    input  logic            full_mode,
    input  logic            entry,
    output logic [ROWS-1:0] seed
);
    localparam int HALF     = ROWS / 2;
    localparam int UP_HEAD  = 0;
    localparam int UP_MID   = HALF;
    localparam int UP_SKIP  = EDGE_SKIP;
    localparam int DN_HEAD  = ROWS - 1;
    localparam int DN_MID   = HALF - 1;
    localparam int DN_SKIP  = ROWS - 1 - EDGE_SKIP;

    // Select seed cells for the active scan direction.
    always_comb begin
        seed = '0;
        if (entry) begin
            if (dir_up) begin
                seed[UP_HEAD] = 1'b1;
                if (dual_en)    seed[UP_MID]  = 1'b1;
                if (!full_mode) seed[UP_SKIP] = 1'b1;
            end else begin
                seed[DN_HEAD] = 1'b1;
                if (dual_en)    seed[DN_MID]  = 1'b1;
                if (!full_mode) seed[DN_SKIP] = 1'b1;
            end
        end
    end

    // R10: a pulse yields one seed per enabled source.
    p_seed_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        entry |-> ($countones(seed) == 32'(1 + int'(dual_en) + int'(!full_mode))));
endmodule

// File: rtl/pin_router.sv
// Assigns entry and exit roles to the two end pins from the direction,
// and masks the exit value while reset is held.
// Assumes: the pad logic uses the *_oe outputs to turn the pins around.
module pin_router (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_up,
    input  logic lo_pin_in,
    input  logic hi_pin_in,
    input  logic lo_cell,
    input  logic hi_cell,
    output logic entry,
    output logic lo_pin_out,
    output logic lo_pin_oe,
    output logic hi_pin_out,
    output logic hi_pin_oe
);
    // Route entry from the start-end pin, exit to the far-end pin.
    always_comb begin
        entry      = dir_up ? lo_pin_in : hi_pin_in;
        lo_pin_oe  = !dir_up;
        hi_pin_oe  = dir_up;
        lo_pin_out = !dir_up && rst_n && lo_cell;
        hi_pin_out = dir_up && rst_n && hi_cell;
    end

    // R7: the pin that takes the token in never drives a token out.
    p_quiet_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dir_up |-> !lo_pin_out);
endmodule

// File: rtl/shift_core.sv
// Chain of token cells; each edge moves every token one cell in the
// chosen direction and ORs in the seed set. Ends shift in zeros.
// Assumes: synchronous active-low reset.
module shift_core #(
    parameter int ROWS = row_scan_pkg::DEF_ROWS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dir_up,
    input  logic [ROWS-1:0] seed,
    output logic [ROWS-1:0] q
);
    logic [ROWS-1:0] nxt;

    for (genvar i = 0; i < ROWS; i++) begin : g_cell
        logic from_below;
        logic from_above;
        if (i == 0) begin : g_bot
            assign from_below = 1'b0;
        end else begin : g_bot
            assign from_below = q[i-1];
        end
        if (i == ROWS - 1) begin : g_top
            assign from_above = 1'b0;
        end else begin : g_top
            assign from_above = q[i+1];
        end
        assign nxt[i] = (dir_up ? from_below : from_above) | seed[i];
    end

    // Advance the chain, or clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == '0));
    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_up && q[0]) |=> q[1]);
    p_step_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_up && q[ROWS-1]) |=> q[ROWS-2]);
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_up && !q[ROWS-2]) |=> !q[ROWS-1]);
    p_seed_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seed[0] |=> q[0]);
endmodule

// File: rtl/row_token_shifter.sv
// Top of the row-scan token shifter: pin routing, seed decode and the
// cell chain. Row flags come straight from the cell registers.
// Assumes: direction and mode controls are static around clock edges.
module row_token_shifter #(
    parameter int ROWS      = row_scan_pkg::DEF_ROWS,
    parameter int EDGE_SKIP = row_scan_pkg::DEF_EDGE_SKIP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dir_up,
    input  logic            dual_en,
    input  logic            full_mode,
    input  logic            lo_pin_in,
    output logic            lo_pin_out,
    output logic            lo_pin_oe,
    input  logic            hi_pin_in,
    output logic            hi_pin_out,
    output logic            hi_pin_oe,
    output logic [ROWS-1:0] row_active
);
    logic            entry;
    logic [ROWS-1:0] seed;
    logic [ROWS-1:0] cells;

    pin_router u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_up     (dir_up),
        .lo_pin_in  (lo_pin_in),
        .hi_pin_in  (hi_pin_in),
        .lo_cell    (cells[0]),
        .hi_cell    (cells[ROWS-1]),
        .entry      (entry),
        .lo_pin_out (lo_pin_out),
        .lo_pin_oe  (lo_pin_oe),
        .hi_pin_out (hi_pin_out),
        .hi_pin_oe  (hi_pin_oe)
    );

    seed_decoder #(.ROWS(ROWS), .EDGE_SKIP(EDGE_SKIP)) u_seed (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_up    (dir_up),
        .dual_en   (dual_en),
        .full_mode (full_mode),
        .entry     (entry),
        .seed      (seed)
    );

    shift_core #(.ROWS(ROWS)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_up (dir_up),
        .seed   (seed),
        .q      (cells)
    );

    assign row_active = cells;

    // R8: the top-end pin mirrors the last cell while scanning upward.
    p_exit_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_up && row_active[ROWS-1]) |-> hi_pin_out);
endmodule

// File: tb/tb_row_token_shifter.sv
module tb_row_token_shifter;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int ROWS = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_up = 1'b1, dual_en = 1'b0, full_mode = 1'b1;
    logic lo_pin_in = 1'b0, hi_pin_in = 1'b0;
    logic lo_pin_out, lo_pin_oe, hi_pin_out, hi_pin_oe;
    logic [ROWS-1:0] row_active;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int tokq[$];

    always #2.5 clk = ~clk;

    row_token_shifter dut (
        .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .dual_en(dual_en),
        .full_mode(full_mode), .lo_pin_in(lo_pin_in), .lo_pin_out(lo_pin_out),
        .lo_pin_oe(lo_pin_oe), .hi_pin_in(hi_pin_in), .hi_pin_out(hi_pin_out),
        .hi_pin_oe(hi_pin_oe), .row_active(row_active)
    );

    function automatic logic [ROWS-1:0] model_rows();
        logic [ROWS-1:0] v = '0;
        foreach (tokq[k]) v[tokq[k]] = 1'b1;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, logic [ROWS-1:0] act, logic [ROWS-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Seeds a pulse places in the model, per R4, R5 and R6.
    function automatic void add_seeds(bit up, bit dual, bit full);
        if (up) begin
            tokq.push_back(0);
            if (dual) tokq.push_back(64);
            if (!full) tokq.push_back(4);
        end else begin
            tokq.push_back(127);
            if (dual) tokq.push_back(63);
            if (!full) tokq.push_back(123);
        end
    endfunction

    // One cycle: set inputs, compare, advance model to the next edge.
    task automatic cyc(bit rst, bit up, bit dual, bit full, bit lo, bit hi);
        logic [ROWS-1:0] m;
        logic [ROWS-1:0] pins_e, pins_a;
        int nq[$];
        rst_n = rst; dir_up = up; dual_en = dual; full_mode = full;
        lo_pin_in = lo; hi_pin_in = hi;
        #1;
        m = model_rows();
        chk(row_active == m, up ? "R2 rows" : "R3 rows", row_active, m);
        pins_e = '0;
        pins_e[0] = !up && rst && m[0];
        pins_e[1] = up && rst && m[ROWS-1];
        pins_e[2] = !up;
        pins_e[3] = up;
        pins_a = '0;
        pins_a[0] = lo_pin_out; pins_a[1] = hi_pin_out;
        pins_a[2] = lo_pin_oe;  pins_a[3] = hi_pin_oe;
        chk(pins_a == pins_e, "R7/R8 pins", pins_a, pins_e);
        if (!rst) begin
            tokq.delete();
        end else begin
            foreach (tokq[k]) begin
                int p = up ? tokq[k] + 1 : tokq[k] - 1;
                if (p >= 0 && p < ROWS) nq.push_back(p);
            end
            tokq = nq;
            if (up ? lo : hi) add_seeds(up, dual, full);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int combo = 0; combo < 8; combo++) begin
            bit up = combo[0];
            bit dual = combo[1];
            bit full = combo[2];
            logic [ROWS-1:0] sv;
            int ns;
            cyc(0, up, dual, full, 0, 0);
            cyc(0, up, dual, full, 0, 0);
            // R1: chain empty after reset
            chk(row_active == '0, "R1 reset clear", row_active, '0);
            // R7: pulse on the exit-side pin is ignored
            cyc(1, up, dual, full, !up, up);
            #1;
            chk(row_active == '0, "R7 wrong pin ignored", row_active, '0);
            // seed pulse on the entry pin
            cyc(1, up, dual, full, up, !up);
            sv = '0;
            sv[up ? 0 : 127] = 1'b1;
            if (dual) sv[up ? 64 : 63] = 1'b1;
            if (!full) sv[up ? 4 : 123] = 1'b1;
            ns = 1 + int'(dual) + int'(!full);
            #1;
            chk(row_active == sv, !full ? "R6 seeds" : (dual ? "R5 seeds" : "R4 seeds"),
                row_active, sv);
            chk($countones(row_active) == ns, "R10 active count",
                ROWS'($countones(row_active)), ROWS'(ns));
            for (int s = 0; s < ROWS - 1; s++) cyc(1, up, dual, full, 0, 0);
            // R8: the head token now sits in the last cell and shows on exit pin
            chk((up ? hi_pin_out : lo_pin_out) == 1'b1, "R8 exit pulse",
                ROWS'(up ? hi_pin_out : lo_pin_out), ROWS'(1));
            cyc(1, up, dual, full, 0, 0);
            #1;
            // R9: no wrap-around once every token has left
            chk(row_active == '0, "R9 chain empty", row_active, '0);
        end
        // R1: reset while a token sits at the exit masks the exit at once
        cyc(0, 1, 0, 1, 0, 0);
        cyc(1, 1, 0, 1, 1, 0);
        for (int s = 0; s < ROWS - 1; s++) cyc(1, 1, 0, 1, 0, 0);
        rst_n = 1'b0;
        #1;
        chk(hi_pin_out == 1'b0, "R1 exit masked", ROWS'(hi_pin_out), '0);
        cyc(0, 1, 0, 1, 0, 0);
        #1;
        chk(row_active == '0, "R1 reset mid-scan", row_active, '0);
        // R2/R3: direction reversal mid-scan
        cyc(1, 1, 0, 1, 1, 0);
        for (int s = 0; s < 10; s++) cyc(1, 1, 0, 1, 0, 0);
        for (int s = 0; s < 14; s++) cyc(1, 0, 0, 1, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule